// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under an element mask, one element per clock. In compress mode it gathers the source elements whose mask bit is set and packs them, lowest index first, into the bottom of the destination. It also reports how many elements were packed. In expand mode it does the reverse: consecutive source elements, starting at element 0, are scattered to the destination positions whose mask bit is set.

A caller presents the operation select, a vector length, the mask, the source vector and the current destination contents, then pulses start. All operands are captured on that edge. The unit walks elements 0 to length-1 and pulses done when it finishes. The result vector and the element count then hold until the next accepted start.

Destination slots that the operation does not write keep the old destination contents supplied at start. A new start may be raised in the same cycle as done, so operations can run back to back.

Top module: `vmask_pack_unit`

## Requirements
- R1: After reset, done_o is low, count_o is 0 and result_o is all zero.
- R2: In compress mode (op_expand_i = 0), the j-th source element, counting from 0 in increasing index order among the elements whose mask bit is set, appears in result element j (element i occupies result_o bits [i*ELEM_W +: ELEM_W]).
- R3: In compress mode, result elements at positions at or above the packed count equal the old destination elements captured at start.
- R4: When done_o is high, count_o equals the number of set mask bits among elements 0 to length-1.
- R5: In expand mode (op_expand_i = 1), the j-th source element goes to the position of the j-th set mask bit, counting from 0 in increasing index order.
- R6: In expand mode, result elements whose mask bit is clear, or that lie at or above the length, equal the old destination elements.
- R7: Mask bits at positions at or above the length have no effect on result_o or count_o.
- R8: If start_i is accepted at a clock edge, done_o is high for exactly the one cycle that follows the length-th later edge. For a length of 0, that is the cycle directly after the accepting edge.
- R9: start_i raised while an operation is still walking its elements is ignored, and the running operation finishes unchanged.
- R10: start_i raised in the cycle in which done_o is high is accepted. During that cycle result_o and count_o still show the finishing operation.
- R11: A mask with no set bit below the length gives count_o = 0 and result_o equal to the old destination.
- R12: A length input greater than MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; operands are captured when accepted |
| op_expand_i | input | 1 | 0 selects compress, 1 selects expand |
| vlen_i | input | $clog2(MAX_VL+1) | Number of elements taking part |
| mask_i | input | MAX_VL | One mask bit per element, bit i for element i |
| src_i | input | MAX_VL*ELEM_W | Source vector, element i at bits [i*ELEM_W +: ELEM_W] |
| old_i | input | MAX_VL*ELEM_W | Previous destination contents |
| result_o | output | MAX_VL*ELEM_W | Destination vector |
| count_o | output | $clog2(MAX_VL+1) | Number of elements moved (mask population count below length) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can coincide are the completion of one operation and the acceptance of the next: done_o and an accepted start_i share a cycle. The sweep provokes this by raising start_i with fresh operands in the very cycle in which done is observed, for every second combination of mode, length and mask. The finished result and count are judged in that cycle, and the new operation's result is judged at its own done. A start raised while elements are still being walked is also injected, and the running operation's timing and result must be unchanged.

// File: rtl/vmpu_pkg.sv
package vmpu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } vmpu_state_e;

   typedef enum logic {
      OP_COMPRESS = 1'b0,
      OP_EXPAND   = 1'b1
   } vmpu_op_e;

endpackage

// File: rtl/vmpu_ctrl.sv
module vmpu_ctrl
   import vmpu_pkg::*;
#(
   parameter int MAX_VL = 8,
   parameter int VL_W   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [VL_W-1:0] vlen_i,
   output logic            accept_o,
   output logic            step_o,
   output logic            done_o,
   output logic [VL_W-1:0] idx_o,
   output logic [VL_W-1:0] vlen_q_o,
   output logic [VL_W-1:0] vlen_eff_o
);

   localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

   vmpu_state_e     state_q;
   logic [VL_W-1:0] idx_q;
   logic [VL_W-1:0] vlen_q;
   logic [VL_W-1:0] vlen_eff;
   logic            last_elem;

   // lengths above the register size saturate (R12)
   assign vlen_eff   = (vlen_i > VL_CAP) ? VL_CAP : vlen_i;
   assign accept_o   = start_i && (state_q != ST_RUN);
   assign step_o     = (state_q == ST_RUN);
   assign done_o     = (state_q == ST_FIN);
   assign last_elem  = (idx_q == (vlen_q - 1'b1));
   assign idx_o      = idx_q;
   assign vlen_q_o   = vlen_q;
   assign vlen_eff_o = vlen_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         vlen_q  <= '0;
      end else if (accept_o) begin
         vlen_q  <= vlen_eff;
         idx_q   <= '0;
         state_q <= (vlen_eff == '0) ? ST_FIN : ST_RUN;
      end else begin
         case (state_q)
            ST_RUN: begin
               idx_q <= idx_q + 1'b1;
               if (last_elem) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_idx_in_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (idx_q < vlen_q));

   p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FIN && !start_i) |=> (state_q == ST_IDLE));

   p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !last_elem) |=> (state_q == ST_RUN && $stable(vlen_q)));

   p_len_capped_r12: assert property (@(posedge clk) disable iff (!rst_n)
      vlen_q <= VL_CAP);

endmodule

// File: rtl/vmpu_elem_pick.sv
module vmpu_elem_pick #(
   parameter int ELEM_W = 8,
   parameter int NUM    = 8,
   parameter int IDX_W  = 4,
   parameter bit ONEHOT = 1'b1
) (
   input  logic [NUM*ELEM_W-1:0] vec_i,
   input  logic [IDX_W-1:0]      idx_i,
   output logic [ELEM_W-1:0]     elem_o
);

   if (ONEHOT) begin : g_onehot
      // AND-OR select: flat depth, one comparator per element
      always_comb begin
         elem_o = '0;
         for (int i = 0; i < NUM; i++) begin
            if (idx_i == IDX_W'(i)) elem_o = elem_o | vec_i[i*ELEM_W +: ELEM_W];
         end
      end
   end else begin : g_indexed
      // indexed part-select: lets synthesis build a binary mux tree
      always_comb begin
         elem_o = '0;
         if (idx_i < IDX_W'(NUM)) elem_o = vec_i[int'(idx_i)*ELEM_W +: ELEM_W];
      end
   end

endmodule

// File: rtl/vmpu_dest_bank.sv
module vmpu_dest_bank #(
   parameter int ELEM_W = 8,
   parameter int NUM    = 8,
   parameter int IDX_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [NUM*ELEM_W-1:0] load_data_i,
   input  logic                  we_i,
   input  logic [IDX_W-1:0]      waddr_i,
   input  logic [ELEM_W-1:0]     wdata_i,
   output logic [NUM*ELEM_W-1:0] data_o
);

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic [ELEM_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                slot_q <= '0;
         else if (load_i)                           slot_q <= load_data_i[g*ELEM_W +: ELEM_W];
         else if (we_i && waddr_i == IDX_W'(g))     slot_q <= wdata_i;
      end
      assign data_o[g*ELEM_W +: ELEM_W] = slot_q;
   end

   p_no_load_write_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && we_i));

   p_write_addr_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> (waddr_i < IDX_W'(NUM)));

endmodule

// File: rtl/vmask_pack_unit.sv
module vmask_pack_unit
   import vmpu_pkg::*;
#(
   parameter int ELEM_W      = 8,
   parameter int MAX_VL      = 8,
   parameter bit ONEHOT_PICK = 1'b1,
   localparam int VL_W       = $clog2(MAX_VL + 1),
   localparam int VEC_W      = MAX_VL * ELEM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_expand_i,
   input  logic [VL_W-1:0]   vlen_i,
   input  logic [MAX_VL-1:0] mask_i,
   input  logic [VEC_W-1:0]  src_i,
   input  logic [VEC_W-1:0]  old_i,
   output logic [VEC_W-1:0]  result_o,
   output logic [VL_W-1:0]   count_o,
   output logic              done_o
);

   if (MAX_VL < 2) begin : g_bad_vl
      $error("MAX_VL must be at least 2");
   end
   if (ELEM_W < 1) begin : g_bad_w
      $error("ELEM_W must be at least 1");
   end

   logic              accept;
   logic              step;
   logic [VL_W-1:0]   idx;
   logic [VL_W-1:0]   vlen_q;
   logic [VL_W-1:0]   vlen_eff;
   logic [MAX_VL-1:0] lane_en;
   logic [MAX_VL-1:0] mask_q;
   logic [VEC_W-1:0]  src_q;
   vmpu_op_e          op_q;
   logic [VL_W-1:0]   cnt_q;
   logic              mbit;
   logic [VL_W-1:0]   rd_idx;
   logic [VL_W-1:0]   wr_idx;
   logic [ELEM_W-1:0] picked;
   logic              wr_en;

   vmpu_ctrl #(
      .MAX_VL (MAX_VL),
      .VL_W   (VL_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .vlen_i     (vlen_i),
      .accept_o   (accept),
      .step_o     (step),
      .done_o     (done_o),
      .idx_o      (idx),
      .vlen_q_o   (vlen_q),
      .vlen_eff_o (vlen_eff)
   );

   // mask bits beyond the length are dropped at capture (R7)
   always_comb begin
      for (int i = 0; i < MAX_VL; i++) lane_en[i] = (VL_W'(i) < vlen_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         src_q  <= '0;
         op_q   <= OP_COMPRESS;
      end else if (accept) begin
         mask_q <= mask_i & lane_en;
         src_q  <= src_i;
         op_q   <= op_expand_i ? OP_EXPAND : OP_COMPRESS;
      end
   end

   always_comb begin
      mbit = 1'b0;
      for (int i = 0; i < MAX_VL; i++) begin
         if (idx == VL_W'(i)) mbit = mask_q[i];
      end
   end

   // packed-side pointer: write slot for compress, read slot for expand
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (accept)        cnt_q <= '0;
      else if (step && mbit)  cnt_q <= cnt_q + 1'b1;
   end

   assign rd_idx = (op_q == OP_EXPAND) ? cnt_q : idx;
   assign wr_idx = (op_q == OP_EXPAND) ? idx   : cnt_q;
   assign wr_en  = step && mbit;

   vmpu_elem_pick #(
      .ELEM_W (ELEM_W),
      .NUM    (MAX_VL),
      .IDX_W  (VL_W),
      .ONEHOT (ONEHOT_PICK)
   ) u_pick (
      .vec_i  (src_q),
      .idx_i  (rd_idx),
      .elem_o (picked)
   );

   vmpu_dest_bank #(
      .ELEM_W (ELEM_W),
      .NUM    (MAX_VL),
      .IDX_W  (VL_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept),
      .load_data_i (old_i),
      .we_i        (wr_en),
      .waddr_i     (wr_idx),
      .wdata_i     (picked),
      .data_o      (result_o)
   );

   assign count_o = cnt_q;

   p_count_le_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= vlen_q);

   p_count_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mbit) |=> (count_o == $past(count_o) + 1'b1));

   p_packed_behind_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt_q <= idx));

   p_unmasked_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mbit) |=> $stable(result_o));

   p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !accept) |=> ($stable(result_o) && $stable(count_o)));

endmodule

// File: tb/vmask_pack_unit_bench.sv
`timescale 1ns/1ps
module vmask_pack_unit_bench;

   localparam int W  = 8;
   localparam int N  = 4;
   localparam int LW = $clog2(N + 1);
   localparam int VW = N * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_expand_i = 1'b0;
   logic [LW-1:0] vlen_i = '0;
   logic [N-1:0]  mask_i = '0;
   logic [VW-1:0] src_i = '0;
   logic [VW-1:0] old_i = '0;
   logic [VW-1:0] result_o;
   logic [LW-1:0] count_o;
   logic          done_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vmask_pack_unit #(
      .ELEM_W      (W),
      .MAX_VL      (N),
      .ONEHOT_PICK (1'b1)
   ) u_vmask_pack_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .op_expand_i (op_expand_i),
      .vlen_i      (vlen_i),
      .mask_i      (mask_i),
      .src_i       (src_i),
      .old_i       (old_i),
      .result_o    (result_o),
      .count_o     (count_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] mk_src(input int seed);
      logic [VW-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed + i * 3 + 1);
      return v;
   endfunction

   function automatic logic [VW-1:0] mk_old(input int seed);
      logic [VW-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed * 7 + 8'h5A + i * 5);
      return v;
   endfunction

   function automatic int clamp_len(input int vl);
      return (vl > N) ? N : vl;
   endfunction

   task automatic drive_start(input bit op, input int vl, input logic [N-1:0] m, input int seed);
      start_i     = 1'b1;
      op_expand_i = op;
      vlen_i      = LW'(vl);
      mask_i      = m;
      src_i       = mk_src(seed);
      old_i       = mk_old(seed);
   endtask

   // called right after drive_start at a falling edge; returns at the done falling edge
   task automatic finish_op(input bit op, input int vl, input logic [N-1:0] m, input int seed,
                            input bit poke, input string ctx);
      logic [VW-1:0] src, exp;
      int            vle, k;
      bit            zero_mask;
      string         tag;
      vle = clamp_len(vl);
      src = mk_src(seed);
      exp = mk_old(seed);
      k = 0;
      for (int i = 0; i < vle; i++) begin
         if (m[i]) begin
            if (!op) exp[k*W +: W] = src[i*W +: W];
            else     exp[i*W +: W] = src[k*W +: W];
            k++;
         end
      end
      zero_mask = (k == 0);
      @(negedge clk);
      start_i = 1'b0;
      mask_i  = ~mask_i;
      src_i   = ~src_i;
      old_i   = ~old_i;
      for (int c = 1; c <= vle + 1; c++) begin
         if (c > 1) @(negedge clk);
         if (poke && c == 1) begin
            start_i     = 1'b1;
            vlen_i      = '0;
            op_expand_i = ~op_expand_i;
         end
         if (poke && c == 2) start_i = 1'b0;
         chk(done_o == (c == vle + 1), $sformatf("R8 %s done timing op=%0d vl=%0d cycle=%0d", ctx, op, vl, c),
             64'(done_o), 64'(c == vle + 1));
      end
      tag = zero_mask ? "R11 R4" : "R4";
      chk(count_o == LW'(k), $sformatf("%s %s count op=%0d vl=%0d mask=%0h", tag, ctx, op, vl, m),
          64'(count_o), 64'(k));
      for (int i = 0; i < N; i++) begin
         if (zero_mask)            tag = "R11";
         else if (i >= vle && m[i]) tag = "R7";
         else if (!op)             tag = (i < k) ? "R2" : "R3";
         else                      tag = (i < vle && m[i]) ? "R5" : "R6";
         if (vl > N) tag = {tag, " R12"};
         chk(result_o[i*W +: W] == exp[i*W +: W],
             $sformatf("%s %s elem %0d op=%0d vl=%0d mask=%0h", tag, ctx, i, op, vl, m),
             64'(result_o[i*W +: W]), 64'(exp[i*W +: W]));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done_o == 1'b0, "R1 reset done", 64'(done_o), 64'd0);
      chk(count_o == '0, "R1 reset count", 64'(count_o), 64'd0);
      chk(result_o == '0, "R1 reset result", 64'(result_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep: mode x length (including over-length) x every mask
      for (int t = 0; t < 2 * 6 * 16; t++) begin
         bit            op;
         int            vl;
         logic [N-1:0]  m;
         bit            chained;
         op = (t / 96) != 0;
         vl = (t / 16) % 6;
         m  = N'(t % 16);
         chained = (t % 2) == 1;
         drive_start(op, vl, m, t * 13 + 1);
         finish_op(op, vl, m, t * 13 + 1, 1'b0, chained ? "R10 back-to-back" : "sweep");
         if (!chained) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R8 done lasts one cycle", 64'(done_o), 64'd0);
         end
      end
      @(negedge clk);

      // start pulses injected while elements are still being walked
      for (int t = 0; t < 8; t++) begin
         bit           op;
         int           vl;
         logic [N-1:0] m;
         op = t[0];
         vl = 2 + (t % 3);
         m  = N'(t * 5 + 3);
         drive_start(op, vl, m, 200 + t);
         finish_op(op, vl, m, 200 + t, 1'b1, "R9 busy start");
         @(negedge clk);
         chk(done_o == 1'b0, "R9 no extra operation", 64'(done_o), 64'd0);
         @(negedge clk);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule